// File: doc/BRIEF.md
# Byte-Lane Interleaved Memory Bank

This block is a 4 KB data store made of four byte-wide lanes, 1024 entries each. Consecutive byte addresses rotate through the lanes: the two lowest address bits pick the lane and bits 11..2 pick the entry within it. The block decodes an access size (byte, halfword or word) and a byte address into a per-lane enable vector. It then writes the enabled lanes from a 32-bit data bus, or reads them back onto it. Each lane owns one fixed byte position of that bus.

A requester drives the address, a read/not-write select and one of three size strobes for one clock cycle. One cycle later the block presents the registered lane enables, the lane index, the read data and an error flag. The block rejects an access and changes no stored byte if any of these is true: the address reaches beyond 4 KB, the access is misaligned for its size, or more than one size strobe is raised.

Top module: `bytelane_mem`

## Requirements
- R1: A lone byte strobe at a valid address enables exactly one lane, the lane whose number equals address bits [1:0] (lane_en bit n set for lane n).
- R2: A lone halfword strobe at an even valid address enables lanes 0 and 1 (lane_en = 4'b0011) when address bit 1 is 0, and lanes 2 and 3 (4'b1100) when it is 1.
- R3: A lone word strobe at a valid address with bits [1:0] = 0 enables all four lanes (lane_en = 4'b1111).
- R4: lane_idx equals address bits [11:2] of the access and appears, with lane_en and err, one clock cycle after the access is presented.
- R5: A write (rd_nwr = 0) stores byte lane n of wr_data (bits [8n+7:8n]) into lane n at the indexed entry, for each enabled lane only. Bytes in disabled lanes keep their values.
- R6: A read (rd_nwr = 1) returns the stored byte of each enabled lane on its byte position of rd_data one cycle later. Every disabled lane, and every lane during a write or an idle cycle, reads as zero.
- R7: An access with any of address bits [31:12] set enables no lane, raises err for that one result cycle, and changes no stored byte.
- R8: A halfword with address bit 0 set, or a word with address bits [1:0] nonzero, enables no lane, raises err, and changes no stored byte.
- R9: An access with two or more size strobes raised enables no lane, raises err, and changes no stored byte.
- R10: While rst is high and in the first cycle after it, lane_en, lane_idx, rd_data and err are all zero.
- R11: A cycle with no size strobe enables no lane and leaves err low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 32 | Byte address of the access |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| sz_byte | input | 1 | Byte access strobe |
| sz_half | input | 1 | Halfword access strobe |
| sz_word | input | 1 | Word access strobe |
| wr_data | input | 32 | Write data, byte n feeds lane n |
| lane_en | output | 4 | Registered per-lane enable of the last access |
| lane_idx | output | 10 | Registered entry index of the last access |
| rd_data | output | 32 | Read data, byte n from lane n, zero where disabled |
| err | output | 1 | One-cycle flag for a rejected access |

## Verification
Byte accesses sweep all four lane positions, including the first and last entries, so a swapped or shorted lane decode shows up as data on the wrong byte. Halfwords at both even offsets and a word write, overlaid with byte writes, tell apart lane selection on bit 1 from selection on bit 0, and show whether partial writes preserve their neighbours. Rejected accesses use an over-range address that aliases a written entry, two misaligned shapes and a double strobe. Each one is followed by a read-back, which separates a correct rejection from one that only masks the flag.

// File: rtl/bl_pkg.sv
package bl_pkg;
  typedef struct packed {
    logic b;
    logic h;
    logic w;
  } acc_size_t;
endpackage

// File: rtl/bl_decode.sv
module bl_decode #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int IDX_W  = 10,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0]      addr,
  input  bl_pkg::acc_size_t      size,
  output logic [LANES-1:0]       en,
  output logic                   fault
);
  logic [LANES-1:0] en_raw;
  logic any_sz, multi_sz, out_range, misalign;

  for (genvar l = 0; l < LANES; l++) begin : g_sel
    localparam logic [SEL_W-1:0] LID = SEL_W'(l);
    assign en_raw[l] = size.w
                     | (size.h & (addr[SEL_W-1:1] == LID[SEL_W-1:1]))
                     | (size.b & (addr[SEL_W-1:0] == LID));
  end

  always_comb begin
    any_sz    = size.b | size.h | size.w;
    multi_sz  = (size.b & size.h) | (size.b & size.w) | (size.h & size.w);
    out_range = |addr[ADDR_W-1:SEL_W+IDX_W];
    misalign  = (size.h & addr[0]) | (size.w & (|addr[SEL_W-1:0]));
    fault     = any_sz & (multi_sz | out_range | misalign);
    en        = fault ? '0 : en_raw;
  end
endmodule

// File: rtl/bl_lane.sv
module bl_lane #(
  parameter int IDX_W  = 10,
  parameter int BYTE_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rd,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && !rd) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)            rdata <= '0;
    else if (en && rd)  rdata <= mem[idx];
    else                rdata <= '0;
  end

  a_r6_lane_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(en && rd) |=> (rdata == '0));
endmodule

// File: rtl/bytelane_mem.sv
module bytelane_mem #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int IDX_W  = 10,
  parameter int BYTE_W = 8,
  localparam int SEL_W  = $clog2(LANES),
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              rd_nwr,
  input  logic              sz_byte,
  input  logic              sz_half,
  input  logic              sz_word,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  lane_en,
  output logic [IDX_W-1:0]  lane_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              err
);
  bl_pkg::acc_size_t size;
  logic [LANES-1:0]  en_c, en_go;
  logic              fault_c;
  logic [IDX_W-1:0]  idx_c;

  assign size  = '{b: sz_byte, h: sz_half, w: sz_word};
  assign idx_c = acc_addr[SEL_W+IDX_W-1:SEL_W];
  assign en_go = rst ? '0 : en_c;

  bl_decode #(.ADDR_W(ADDR_W), .LANES(LANES), .IDX_W(IDX_W)) u_dec (
    .addr  (acc_addr),
    .size  (size),
    .en    (en_c),
    .fault (fault_c)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bl_lane #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .en    (en_go[l]),
      .rd    (rd_nwr),
      .idx   (idx_c),
      .wdata (wr_data[l*BYTE_W +: BYTE_W]),
      .rdata (rd_data[l*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_en  <= '0;
      lane_idx <= '0;
      err      <= 1'b0;
    end else begin
      lane_en  <= en_c;
      lane_idx <= idx_c;
      err      <= fault_c;
    end
  end

  a_r1_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
    (sz_byte && !sz_half && !sz_word && !fault_c) |=> ($countones(lane_en) == 1));

  a_r3_word_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (sz_word && !sz_byte && !sz_half && !fault_c) |=> (lane_en == '1));

  a_r4_idx_follows: assert property (@(posedge clk) disable iff (rst)
    (sz_byte || sz_half || sz_word) |=> (lane_idx == $past(acc_addr[SEL_W+IDX_W-1:SEL_W])));

  a_r7_err_no_enable: assert property (@(posedge clk) disable iff (rst)
    err |-> (lane_en == '0));

  a_r6_disabled_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (lane_en == '0) |-> (rd_data == '0));
endmodule

// File: tb/tb_bytelane_mem.sv
module tb_bytelane_mem;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] acc_addr = '0;
  logic        rd_nwr = 1'b1;
  logic        sz_byte = 1'b0, sz_half = 1'b0, sz_word = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  lane_en;
  logic [9:0]  lane_idx;
  logic [31:0] rd_data;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [0:4095];

  always #10 clk = ~clk;

  bytelane_mem dut (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .rd_nwr(rd_nwr),
    .sz_byte(sz_byte), .sz_half(sz_half), .sz_word(sz_word),
    .wr_data(wr_data), .lane_en(lane_en), .lane_idx(lane_idx),
    .rd_data(rd_data), .err(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one access, wait one cycle, check all registered results.
  task automatic op(input string req, input logic [31:0] a, input logic rd,
                    input logic b, input logic h, input logic w, input logic [31:0] wd);
    logic any, bad;
    logic [3:0] exp_en;
    logic [31:0] exp_rd;
    any = b | h | w;
    bad = any & (((b & h) | (b & w) | (h & w)) | (|a[31:12]) | (h & a[0]) | (w & (|a[1:0])));
    exp_en = 4'b0000;
    if (!bad) begin
      if (w)      exp_en = 4'b1111;
      else if (h) exp_en = a[1] ? 4'b1100 : 4'b0011;
      else if (b) exp_en = 4'b0001 << a[1:0];
    end
    exp_rd = '0;
    for (int n = 0; n < 4; n++)
      if (exp_en[n] && rd) exp_rd[8*n +: 8] = model[{a[11:2], 2'(n)}];
    acc_addr = a; rd_nwr = rd; sz_byte = b; sz_half = h; sz_word = w; wr_data = wd;
    @(negedge clk);
    check({req, " lane_en"}, {28'd0, lane_en}, {28'd0, exp_en});
    check({req, " err"}, {31'd0, err}, {31'd0, bad});
    check({req, " rd_data"}, rd_data, exp_rd);
    if (any) check({req, " R4 lane_idx"}, {22'd0, lane_idx}, {22'd0, a[11:2]});
    for (int n = 0; n < 4; n++)
      if (exp_en[n] && !rd) model[{a[11:2], 2'(n)}] = wd[8*n +: 8];
    sz_byte = 0; sz_half = 0; sz_word = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R10 lane_en", {28'd0, lane_en}, 32'd0);
    check("R10 err", {31'd0, err}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 rd_data", rd_data, 32'd0);
    check("R10 lane_idx", {22'd0, lane_idx}, 32'd0);
  endtask

  task automatic t_bytes();
    for (int i = 0; i < 8; i++) op("R1 R5 byte wr", i, 0, 1, 0, 0, {4{8'(8'h10 + i)}});
    op("R1 R5 byte wr top", 32'hFFF, 0, 1, 0, 0, 32'hA5A5_A5A5);
    op("R1 R5 byte wr 401", 32'h401, 0, 1, 0, 0, 32'h0000_7700);
    for (int i = 0; i < 8; i++) op("R1 R6 byte rd", i, 1, 1, 0, 0, 0);
    op("R6 byte rd top", 32'hFFF, 1, 1, 0, 0, 0);
    op("R6 byte rd 401", 32'h401, 1, 1, 0, 0, 0);
    check("R6 lane1 position", rd_data, 32'h0000_7700);
  endtask

  task automatic t_half_word();
    op("R2 half lo", 32'h010, 0, 0, 1, 0, 32'h1111_BEEF);
    op("R2 half hi", 32'h012, 0, 0, 1, 0, 32'hCAFE_2222);
    op("R3 word rd", 32'h010, 1, 0, 0, 1, 0);
    check("R3 R5 merged word", rd_data, 32'hCAFE_BEEF);
    op("R2 half rd hi", 32'h012, 1, 0, 1, 0, 0);
    check("R6 half hi zero low", rd_data, 32'hCAFE_0000);
    op("R5 byte overlay", 32'h011, 0, 1, 0, 0, 32'h0000_5500);
    op("R5 word rd", 32'h010, 1, 0, 0, 1, 0);
    check("R5 neighbours kept", rd_data, 32'hCAFE_55EF);
    op("R3 word wr", 32'h3FC, 0, 0, 0, 1, 32'h0403_0201);
    op("R6 byte rd 3FD", 32'h3FD, 1, 1, 0, 0, 0);
    check("R6 single byte", rd_data, 32'h0000_0200);
  endtask

  task automatic t_reject();
    op("R7 out of range wr", 32'h0000_1010, 0, 0, 0, 1, 32'hFFFF_FFFF);
    op("R11 idle after err", 32'h0, 1, 0, 0, 0, 0);
    check("R7 err one cycle", {31'd0, err}, 32'd0);
    op("R7 out of range rd", 32'h8000_0010, 1, 0, 0, 1, 0);
    op("R8 half odd", 32'h011, 0, 0, 1, 0, 32'hFFFF_FFFF);
    op("R8 word unaligned", 32'h012, 0, 0, 0, 1, 32'hFFFF_FFFF);
    op("R9 byte+word", 32'h010, 0, 1, 0, 1, 32'hFFFF_FFFF);
    op("R9 half+byte", 32'h010, 0, 1, 1, 0, 32'hFFFF_FFFF);
    op("R7 R8 R9 readback", 32'h010, 1, 0, 0, 1, 0);
    check("R7 R8 R9 unchanged", rd_data, 32'hCAFE_55EF);
  endtask

  task automatic t_idle();
    op("R11 idle", 32'h004, 0, 0, 0, 0, 32'hDEAD_BEEF);
    op("R11 readback", 32'h004, 1, 0, 0, 1, 0);
    check("R11 no write", rd_data, 32'h1716_1514);
  endtask

  initial begin
    t_reset();
    t_bytes();
    t_half_word();
    t_reject();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule